// File: doc/BRIEF.md
# Masked Multi-Slot I2C Address Matcher

This block sits behind an I2C bit engine and decides whether the first byte of a transfer, which the engine has already shifted in after a START or repeated START, is addressed to this device. It checks the 7-bit address in bits 7:1 of that byte against four programmable address slots. Each slot has its own mask, and a mask bit set to 1 turns the matching address bit into a "don't care". Bit 0, the read/write flag, never takes part in the comparison. The all-zero general-call address is also detected. That check is exact, no mask changes it, and it counts only when a control bit enables it.

On a hit the block raises a sticky interrupt request and reports which slot matched, with the lowest-numbered slot winning when several match. It also keeps the whole received byte so that software can see which address actually arrived, since a masked slot can accept many addresses. Software reaches the slot addresses, the masks, the received byte, the status and the control bit through a small word-indexed register port.

The block also follows whether the device is acting as bus master. While it is master, its own outgoing address byte is not matched. When arbitration is lost, detection comes back at once, so the device can still answer its own address in the same transfer.

Top module: `i2cam_addr_matcher`

## Requirements
- R1: After reset, every slot address, every mask, the general-call enable, the received byte and all status fields read as zero, and `irq` is low.
- R2: A slot hits when bits 7:1 of the address byte equal bits 7:1 of that slot's address on every bit whose mask bit is 0. Bit 0 of the byte (the read/write flag) is ignored.
- R3: A mask bit set to 1 removes that address bit from its own slot's comparison and from no other slot's comparison.
- R4: Register index k (0..3) holds the address of slot k and index 4+k holds the mask of slot k, both in bits 7:1. On these registers, bit 0 and bits 31:8 always read as zero, whatever was written.
- R5: When several slots hit, `hit_slot` gives the lowest-numbered one. Status register index 9 carries the slot number in bits 5:4.
- R6: The general-call address (bits 7:1 all zero) hits only when control register index 10 bit 0 is 1, and the comparison is exact whatever the masks hold. It is reported on `hit_gc` and on status bit 1.
- R7: Any slot or general-call hit sets `irq`, which stays set until a write to index 9 with bit 0 equal to 1. A hit in the same cycle as that clearing write leaves `irq` set.
- R8: Every address byte, whether or not it hits, is stored whole (bits 7:0) and can be read at index 8. The stored value changes only at the next address byte.
- R9: From a `master_start` pulse until `arb_lost` or `bus_stop`, address bytes are not matched. An `arb_lost` pulse in the same cycle as the address byte, or any cycle before it, restores matching for that byte.
- R10: A register write in the same cycle as an address byte does not affect that byte's comparison. It applies from the next address byte onward.
- R11: Every address byte that is matched refreshes `hit_slot_valid` (status bit 2), `hit_slot` and `hit_gc`. A byte that hits nothing clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_start | input | 1 | Pulse: this device starts a transfer as bus master |
| arb_lost | input | 1 | Pulse: master arbitration was lost |
| bus_stop | input | 1 | Pulse: STOP condition seen |
| addr_valid | input | 1 | Pulse: the first byte after START or repeated START is complete |
| addr_byte | input | 8 | The received first byte (address in 7:1, read/write flag in 0) |
| reg_sel | input | IDX_W | Word index of the register to read or write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the register at `reg_sel` |
| irq | output | 1 | Sticky address-match interrupt request |
| hit_slot_valid | output | 1 | The last matched byte hit a slot |
| hit_slot | output | SLOT_W | Lowest slot hit by the last matched byte |
| hit_gc | output | 1 | The last matched byte was an enabled general call |

## Verification
The hardest situation to reach from the ports is arbitration lost in exactly the cycle the address byte completes, together with a byte that would hit a masked slot. It needs a master transfer already under way, a slot whose mask lets the byte through, and an `arb_lost` pulse that lines up with `addr_valid`. Directed steps set up this case, and also a slot-register write and an interrupt clear that each land in the same cycle as a matching byte. The random phase builds most address bytes from a programmed slot address with random flips in its masked bits only, so hits are frequent. It uses sparse random masks and random role pulses mixed with the address bytes.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

  // Width of an I2C slave address (bits 7:1 of the first byte).
  localparam int unsigned ADDR_BITS = 7;

  typedef logic [ADDR_BITS-1:0] i2c_addr_t;

  // A programmed address accepts a received one when every bit outside
  // the don't-care set agrees.
  function automatic logic addr_agrees(i2c_addr_t rx, i2c_addr_t prog, i2c_addr_t dont_care);
    return ((rx ^ prog) & ~dont_care) == '0;
  endfunction

  // General call: all seven address bits zero, never masked.
  function automatic logic is_general_call(i2c_addr_t rx);
    return rx == '0;
  endfunction

endpackage

// File: rtl/i2cam_role.sv
module i2cam_role (
  input  logic clk,
  input  logic rst_n,
  input  logic master_start,
  input  logic arb_lost,
  input  logic bus_stop,
  output logic master_mode,
  output logic detect_en
);

  // Losing arbitration or seeing STOP ends the master role; both win over
  // a start request in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_mode <= 1'b0;
    end else if (arb_lost || bus_stop) begin
      master_mode <= 1'b0;
    end else if (master_start) begin
      master_mode <= 1'b1;
    end
  end

  // Arbitration loss takes effect within the same cycle so the byte that
  // completes alongside it is still examined as a slave.
  assign detect_en = ~master_mode | arb_lost;

endmodule

// File: rtl/i2cam_match.sv
module i2cam_match
  import i2cam_pkg::*;
#(
  parameter int unsigned NSLOTS = 4,
  parameter int unsigned SLOT_W = 2
) (
  input  i2c_addr_t                rx_addr,
  input  i2c_addr_t [NSLOTS-1:0]   prog_addr,
  input  i2c_addr_t [NSLOTS-1:0]   prog_mask,
  input  logic                     gc_en,
  output logic [NSLOTS-1:0]        sel_onehot,
  output logic                     slot_any,
  output logic [SLOT_W-1:0]        slot_idx,
  output logic                     gc_ok
);

  logic [NSLOTS-1:0] raw_hits;

  // One independent masked comparator per slot.
  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    assign raw_hits[g] = addr_agrees(rx_addr, prog_addr[g], prog_mask[g]);
  end

  // Isolate the lowest set bit: lowest slot number has priority.
  assign sel_onehot = raw_hits & (~raw_hits + NSLOTS'(1));
  assign slot_any   = |raw_hits;

  always_comb begin
    slot_idx = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (raw_hits[i]) slot_idx = SLOT_W'(i);
    end
  end

  assign gc_ok = gc_en & is_general_call(rx_addr);

endmodule

// File: rtl/i2cam_regs.sv
module i2cam_regs
  import i2cam_pkg::*;
#(
  parameter int unsigned NSLOTS = 4,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        reg_sel,
  input  logic                    reg_we,
  input  logic [DATA_W-1:0]       reg_wdata,
  input  logic [7:0]              rx_byte,
  input  logic                    st_irq,
  input  logic                    st_gc,
  input  logic                    st_slot_valid,
  input  logic [SLOT_W-1:0]       st_slot,
  output i2c_addr_t [NSLOTS-1:0]  prog_addr,
  output i2c_addr_t [NSLOTS-1:0]  prog_mask,
  output logic                    gc_en,
  output logic                    clr_req,
  output logic [DATA_W-1:0]       reg_rdata
);

  localparam logic [IDX_W-1:0] MASK_BASE = IDX_W'(NSLOTS);
  localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(2 * NSLOTS);
  localparam logic [IDX_W-1:0] STAT_IDX  = IDX_W'(2 * NSLOTS + 1);
  localparam logic [IDX_W-1:0] CTRL_IDX  = IDX_W'(2 * NSLOTS + 2);
  localparam int unsigned SLOT_LSB = 4;

  i2c_addr_t wr_field;
  logic      unused_wdata;

  assign wr_field     = reg_wdata[ADDR_BITS:1];
  assign unused_wdata = ^reg_wdata[DATA_W-1:ADDR_BITS+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_mask <= '0;
      gc_en     <= 1'b0;
    end else if (reg_we) begin
      for (int i = 0; i < NSLOTS; i++) begin
        if (reg_sel == IDX_W'(i))             prog_addr[i] <= wr_field;
        if (reg_sel == MASK_BASE + IDX_W'(i)) prog_mask[i] <= wr_field;
      end
      if (reg_sel == CTRL_IDX) gc_en <= reg_wdata[0];
    end
  end

  // Write-one-to-clear request for the interrupt flag.
  assign clr_req = reg_we && (reg_sel == STAT_IDX) && reg_wdata[0];

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (reg_sel == IDX_W'(i))             reg_rdata[ADDR_BITS:1] = prog_addr[i];
      if (reg_sel == MASK_BASE + IDX_W'(i)) reg_rdata[ADDR_BITS:1] = prog_mask[i];
    end
    if (reg_sel == DATA_IDX) reg_rdata[7:0] = rx_byte;
    if (reg_sel == STAT_IDX) begin
      reg_rdata[0] = st_irq;
      reg_rdata[1] = st_gc;
      reg_rdata[2] = st_slot_valid;
      reg_rdata[SLOT_LSB +: SLOT_W] = st_slot;
    end
    if (reg_sel == CTRL_IDX) reg_rdata[0] = gc_en;
  end

endmodule

// File: rtl/i2cam_addr_matcher.sv
module i2cam_addr_matcher
  import i2cam_pkg::*;
#(
  parameter int unsigned NSLOTS = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_start,
  input  logic              arb_lost,
  input  logic              bus_stop,
  input  logic              addr_valid,
  input  logic [7:0]        addr_byte,
  input  logic [IDX_W-1:0]  reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              hit_slot_valid,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              hit_gc
);

  // Named internal events, visible to the bound checker.
  i2c_addr_t [NSLOTS-1:0] prog_addr;
  i2c_addr_t [NSLOTS-1:0] prog_mask;
  logic                   gc_en;
  logic                   clr_req;
  logic                   master_mode;
  logic                   detect_en;
  logic [NSLOTS-1:0]      sel_onehot;
  logic                   slot_any;
  logic [SLOT_W-1:0]      slot_idx;
  logic                   gc_ok;
  logic                   addr_eval;
  logic                   match_evt;
  logic [7:0]             rx_q;
  logic                   irq_q;
  logic                   gc_q;
  logic                   sv_q;
  logic [SLOT_W-1:0]      slot_q;

  i2cam_role u_role (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_start (master_start),
    .arb_lost     (arb_lost),
    .bus_stop     (bus_stop),
    .master_mode  (master_mode),
    .detect_en    (detect_en)
  );

  i2cam_match #(
    .NSLOTS (NSLOTS),
    .SLOT_W (SLOT_W)
  ) u_match (
    .rx_addr    (addr_byte[ADDR_BITS:1]),
    .prog_addr  (prog_addr),
    .prog_mask  (prog_mask),
    .gc_en      (gc_en),
    .sel_onehot (sel_onehot),
    .slot_any   (slot_any),
    .slot_idx   (slot_idx),
    .gc_ok      (gc_ok)
  );

  i2cam_regs #(
    .NSLOTS (NSLOTS),
    .SLOT_W (SLOT_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_sel       (reg_sel),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .rx_byte       (rx_q),
    .st_irq        (irq_q),
    .st_gc         (gc_q),
    .st_slot_valid (sv_q),
    .st_slot       (slot_q),
    .prog_addr     (prog_addr),
    .prog_mask     (prog_mask),
    .gc_en         (gc_en),
    .clr_req       (clr_req),
    .reg_rdata     (reg_rdata)
  );

  assign addr_eval = addr_valid & detect_en;
  assign match_evt = addr_eval & (slot_any | gc_ok);

  // The comparison uses the register values held before this edge, so a
  // write landing in the same cycle only affects later address bytes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      irq_q  <= 1'b0;
      gc_q   <= 1'b0;
      sv_q   <= 1'b0;
      slot_q <= '0;
    end else begin
      if (addr_valid) rx_q <= addr_byte;
      if (addr_eval) begin
        gc_q   <= gc_ok;
        sv_q   <= slot_any;
        slot_q <= slot_idx;
      end
      if (match_evt)    irq_q <= 1'b1;
      else if (clr_req) irq_q <= 1'b0;
    end
  end

  assign irq            = irq_q;
  assign hit_gc         = gc_q;
  assign hit_slot_valid = sv_q;
  assign hit_slot       = slot_q;

endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker #(
  parameter int unsigned NSLOTS = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic              arb_lost,
  input logic              master_mode,
  input logic              irq,
  input logic              hit_gc,
  input logic              hit_slot_valid,
  input logic              clr_req,
  input logic              match_evt,
  input logic              gc_en,
  input logic [NSLOTS-1:0] sel_onehot,
  input logic [7:0]        rx_q,
  input logic [IDX_W-1:0]  reg_sel,
  input logic [DATA_W-1:0] reg_rdata
);

  // R7: the request only rises after a match event
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(match_evt));

  // R7: the request holds until software clears it
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_req |=> irq);

  // R7: a clear with no competing match drops the request
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && clr_req && !match_evt |=> !irq);

  // R9: while master, an address byte leaves the hit reporting untouched
  p_master_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && master_mode && !arb_lost |=>
      $stable(hit_gc) && $stable(hit_slot_valid) && !$rose(irq));

  // R6: a general-call report requires the enable
  p_gc_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_gc) |-> $past(gc_en));

  // R5: at most one slot is selected
  p_single_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot));

  // R8: the received byte only changes at an address byte
  p_rx_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> $stable(rx_q));

  // R4: unused bits of address and mask registers read as zero
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel < IDX_W'(2 * NSLOTS) |-> reg_rdata[0] == 1'b0 && reg_rdata[DATA_W-1:8] == '0);

endmodule

bind i2cam_addr_matcher i2cam_checker #(
  .NSLOTS (NSLOTS),
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .addr_valid     (addr_valid),
  .arb_lost       (arb_lost),
  .master_mode    (master_mode),
  .irq            (irq),
  .hit_gc         (hit_gc),
  .hit_slot_valid (hit_slot_valid),
  .clr_req        (clr_req),
  .match_evt      (match_evt),
  .gc_en          (gc_en),
  .sel_onehot     (sel_onehot),
  .rx_q           (rx_q),
  .reg_sel        (reg_sel),
  .reg_rdata      (reg_rdata)
);

// File: tb/i2cam_addr_matcher_bench.sv
`timescale 1ns/1ps
module i2cam_addr_matcher_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_start = 1'b0;
  logic        arb_lost = 1'b0;
  logic        bus_stop = 1'b0;
  logic        addr_valid = 1'b0;
  logic [7:0]  addr_byte = '0;
  logic [3:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        hit_slot_valid;
  logic [1:0]  hit_slot;
  logic        hit_gc;

  always #2.5 clk = ~clk;

  i2cam_addr_matcher u_i2cam_addr_matcher (
    .clk            (clk),
    .rst_n          (rst_n),
    .master_start   (master_start),
    .arb_lost       (arb_lost),
    .bus_stop       (bus_stop),
    .addr_valid     (addr_valid),
    .addr_byte      (addr_byte),
    .reg_sel        (reg_sel),
    .reg_we         (reg_we),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .irq            (irq),
    .hit_slot_valid (hit_slot_valid),
    .hit_slot       (hit_slot),
    .hit_gc         (hit_gc)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements.
  logic [6:0] m_adr [4];
  logic [6:0] m_msk [4];
  logic       m_gcen, m_master, m_irq, m_gc, m_sv;
  logic [1:0] m_slot;
  logic [7:0] m_rx;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] s);
    if (s < 4)       return {24'd0, m_adr[s[1:0]], 1'b0};
    else if (s < 8)  return {24'd0, m_msk[s[1:0]], 1'b0};
    else if (s == 8) return {24'd0, m_rx};
    else if (s == 9) return {26'd0, m_slot, 1'b0, m_sv, m_gc, m_irq};
    else if (s == 10) return {31'd0, m_gcen};
    return 32'd0;
  endfunction

  function automatic string tag_for(input logic [3:0] s);
    if (s < 8)       return "R4 register readback";
    else if (s == 8) return "R8 received byte";
    else if (s == 9) return "R11 status register";
    return "R6 control register";
  endfunction

  task automatic step(input logic ms, input logic al, input logic bs, input logic av,
                      input logic [7:0] ab, input logic we, input logic [3:0] sel,
                      input logic [31:0] wd, input string rtag);
    logic       det, any, g;
    logic [1:0] idx;
    master_start = ms; arb_lost = al; bus_stop = bs; addr_valid = av;
    addr_byte = ab; reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    #1;
    master_start = 1'b0; arb_lost = 1'b0; bus_stop = 1'b0;
    addr_valid = 1'b0; reg_we = 1'b0;
    // model: comparison first, with the values before any write this cycle
    det = !m_master || al;
    any = 1'b0; idx = 2'd0; g = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      if (((ab[7:1] ^ m_adr[i]) & ~m_msk[i]) == 7'd0) begin
        any = 1'b1; idx = 2'(i);
      end
    end
    g = m_gcen && (ab[7:1] == 7'd0);
    if (av) m_rx = ab;
    if (av && det) begin m_sv = any; m_slot = idx; m_gc = g; end
    if (av && det && (any || g)) m_irq = 1'b1;
    else if (we && sel == 4'd9 && wd[0]) m_irq = 1'b0;
    if (we) begin
      if (sel < 4)       m_adr[sel[1:0]] = wd[7:1];
      else if (sel < 8)  m_msk[sel[1:0]] = wd[7:1];
      else if (sel == 10) m_gcen = wd[0];
    end
    if (al || bs) m_master = 1'b0;
    else if (ms)  m_master = 1'b1;
    #1;
    chk("R7 interrupt flag", 32'(irq), 32'(m_irq));
    chk("R6 general call flag", 32'(hit_gc), 32'(m_gc));
    chk("R2 slot hit flag", 32'(hit_slot_valid), 32'(m_sv));
    chk("R5 slot index", 32'(hit_slot), 32'(m_slot));
    chk((rtag == "") ? tag_for(sel) : rtag, reg_rdata, exp_rd(sel));
  endtask

  task automatic idle(input logic [3:0] sel, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, sel, 32'd0, tag);
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] wd);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, sel, wd, "");
  endtask

  task automatic addr(input logic [7:0] ab);
    step(1'b0, 1'b0, 1'b0, 1'b1, ab, 1'b0, 4'd9, 32'd0, "");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    for (int i = 0; i < 4; i++) begin m_adr[i] = '0; m_msk[i] = '0; end
    m_gcen = 0; m_master = 0; m_irq = 0; m_gc = 0; m_sv = 0; m_slot = 0; m_rx = 0;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values of every register
    chk("R1 irq after reset", 32'(irq), 32'd0);
    for (int i = 0; i < 11; i++) idle(4'(i), "R1 reset value");

    // R4: reserved bits never read back
    wr(4'd0, 32'hFFFF_FFA1);
    chk("R4 address reserved bits", reg_rdata, 32'h0000_00A0);
    wr(4'd4, 32'hFFFF_FF07);
    chk("R4 mask reserved bits", reg_rdata, 32'h0000_0006);
    wr(4'd1, 32'h22); wr(4'd2, 32'h44); wr(4'd3, 32'h66);

    // R3: masked bits differ, still a hit on slot 0
    addr(8'hA7);
    chk("R3 masked hit irq", 32'(irq), 32'd1);
    chk("R3 masked hit slot", 32'(hit_slot), 32'd0);
    idle(4'd8, "");
    chk("R8 received byte", reg_rdata, 32'h0000_00A7);
    // R2: read/write flag ignored
    addr(8'hA6);
    chk("R2 rw bit ignored", 32'(hit_slot_valid), 32'd1);
    wr(4'd9, 32'd1);
    chk("R7 cleared by write one", 32'(irq), 32'd0);
    // R3: unmasked bit differs
    addr(8'hA9);
    chk("R3 unmasked miss", 32'(hit_slot_valid), 32'd0);
    chk("R11 status after miss", reg_rdata, 32'd0);

    // R5: priority between slots
    wr(4'd5, 32'hFE);
    addr(8'h44);
    chk("R5 lowest slot of 1 and 2", 32'(hit_slot), 32'd1);
    addr(8'hA0);
    chk("R5 lowest slot of 0 and 1", 32'(hit_slot), 32'd0);
    chk("R5 status slot field", reg_rdata, 32'h0000_0005);
    wr(4'd5, 32'h0);

    // R6: general call
    wr(4'd9, 32'd1);
    addr(8'h01);
    chk("R6 general call disabled", 32'(irq), 32'd0);
    wr(4'd10, 32'd1);
    addr(8'h01);
    chk("R6 general call enabled", 32'(hit_gc), 32'd1);
    chk("R6 general call irq", 32'(irq), 32'd1);
    addr(8'h04);
    chk("R6 general call not masked", 32'(hit_gc), 32'd0);

    // R9: master role suppresses matching until arbitration is lost
    wr(4'd9, 32'd1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 4'd9, 32'd0, "");
    addr(8'hA1);
    chk("R9 own address byte ignored as master", 32'(irq), 32'd0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'hA1, 1'b0, 4'd9, 32'd0, "");
    chk("R9 hit with arbitration lost same cycle", 32'(irq), 32'd1);

    // R10: write in the same cycle as the address byte
    wr(4'd9, 32'd1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hA1, 1'b1, 4'd0, 32'hE0, "");
    chk("R10 old address used", 32'(irq), 32'd1);
    wr(4'd9, 32'd1);
    addr(8'hA1);
    chk("R10 new address applies", 32'(hit_slot_valid), 32'd0);

    // R7: hit wins over clear in the same cycle
    wr(4'd0, 32'hA0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hA1, 1'b1, 4'd9, 32'd1, "");
    chk("R7 set wins over clear", 32'(irq), 32'd1);
    idle(4'd8, ""); idle(4'd8, "");
    chk("R8 byte stable between phases", reg_rdata, 32'h0000_00A1);

    // Random phase
    for (int it = 0; it < 4000; it++) begin
      int r, pick, k;
      logic ms, al, bs, av, we;
      logic [7:0] ab;
      logic [3:0] sel;
      logic [31:0] wd;
      r  = $urandom_range(0, 99);
      ms = (r < 4); al = (r >= 4 && r < 8); bs = (r >= 8 && r < 11);
      av = ($urandom_range(0, 99) < 45);
      pick = $urandom_range(0, 3);
      k = $urandom_range(0, 3);
      if (pick == 0)      ab = 8'($urandom);
      else if (pick == 1) ab = {7'd0, 1'($urandom)};
      else ab = {m_adr[k] ^ (m_msk[k] & 7'($urandom)), 1'($urandom)};
      we  = ($urandom_range(0, 99) < 30);
      sel = 4'($urandom_range(0, 11));
      wd  = $urandom;
      if (sel >= 4 && sel < 8) wd = wd & $urandom;
      step(ms, al, bs, av, ab, we, sel, wd, "");
    end

    finish_run();
  end

endmodule